// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block brings an asynchronous DRAM from power-up to a usable state and then keeps its contents alive. After reset it stays silent for a parameterised power-up pause. It then runs a fixed burst of initialization refresh cycles and raises `ready_o`. From that point it owes one refresh every interval. The interval is the refresh period divided by the number of rows, expressed in clocks.

Each refresh cycle uses one of two strobe orderings, selected by `mode_i`. In CAS-before-RAS mode the device's own row counter picks the row: CAS goes low first, RAS follows, and WE is held high. In RAS-only mode the block places a row from its own wrapping counter on the address pins and pulses RAS while CAS stays high.

The block shares the DRAM pins with an access controller. It raises `bus_req_o` while refresh work is owed and starts a cycle only when `bus_gnt_i` is high. Refreshes that fall due while the grant is withheld are counted, up to a limit, and are then issued back to back once the grant returns. The access controller must keep the grant high for as long as `bus_req_o` stays high.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is active and directly after it, `ras_n_o`, `cas_n_o` and `we_n_o` are high, and `bus_req_o` and `ready_o` are low.
- R2: For PWRUP_CYCLES clocks after reset release, the block raises no bus request and drives no strobe low.
- R3: After the pause the block issues exactly INIT_REFRESHES refresh cycles in the mode given by `mode_i`, which is 0 for CAS-before-RAS and 1 for RAS-only. `ready_o` rises only after the precharge of the last of these cycles and then stays high until reset.
- R4: In CAS-before-RAS mode, `cas_n_o` is low for at least one clock before `ras_n_o` falls and stays low for the whole RAS-low time. `we_n_o` stays high throughout.
- R5: In RAS-only mode, `cas_n_o` stays high while `ras_n_o` is low. `addr_o` carries the row from at least one clock before RAS falls and holds it stable through the RAS-low time.
- R6: The RAS-only row address starts at 0 after reset and advances by one after each RAS-only cycle. It is ROW_W bits wide (11 by default) and wraps from all-ones to 0.
- R7: `ras_n_o` stays low for exactly RAS_LOW_CYCLES clocks in every refresh cycle. Between two refresh cycles it is high for at least RAS_PRE_CYCLES clocks.
- R8: Once ready, with the grant given at once, the block issues one refresh per INTERVAL_CYCLES clocks.
- R9: While the grant is withheld, refreshes that fall due are accumulated up to MAX_PENDING and any beyond that are dropped. When the grant returns, the accumulated refreshes are issued back to back.
- R10: A strobe is low only while `bus_gnt_i` is high. No refresh cycle starts while the grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Refresh style: 0 CAS-before-RAS, 1 RAS-only; sampled at the start of each cycle |
| bus_gnt_i | input | 1 | Access controller grants the DRAM pins |
| bus_req_o | output | 1 | Refresh work owed or a refresh cycle in flight |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_o | output | ROW_W | Row address for RAS-only refresh, zero otherwise |
| ready_o | output | 1 | Initialization complete |

## Verification
The block is first run in CAS-before-RAS mode with the grant following the request at once. This separates the silent pause, the exact initialization count and the moment ready rises from the steady interval rate. The grant is then withheld across several intervals and released. The size of the burst that follows shows whether owed refreshes saturate at the limit or are lost or overcounted. A RAS-only run after a fresh reset checks the other strobe ordering and follows the row address across its wrap. Throughout all runs, a monitor checks strobe order, RAS widths, precharge gaps and whether the grant was held for every refresh cycle.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_PWRUP, PH_INIT, PH_RUN} phase_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CAS_LEAD, ST_ROW_SETUP, ST_RAS_ACT, ST_PRECHG} strobe_st_e;
  localparam logic MODE_CBR = 1'b0;
  localparam logic MODE_ROR = 1'b1;
endpackage

// File: rtl/ref_phase_ctrl.sv
module ref_phase_ctrl import dram_ref_pkg::*; #(
  parameter int PWRUP_CYCLES   = 20000,
  parameter int INIT_REFRESHES = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cyc_done_i,
  output phase_e phase_o
);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam int IW = $clog2(INIT_REFRESHES + 1);

  phase_e        phase_q;
  logic [PW-1:0] pw_cnt_q;
  logic [IW-1:0] init_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PWRUP;
      pw_cnt_q    <= '0;
      init_left_q <= IW'(INIT_REFRESHES);
    end else begin
      case (phase_q)
        PH_PWRUP: begin
          if (pw_cnt_q == PW'(PWRUP_CYCLES - 1)) phase_q <= PH_INIT;
          else pw_cnt_q <= pw_cnt_q + 1'b1;
        end
        PH_INIT: begin
          if (cyc_done_i) begin
            init_left_q <= init_left_q - 1'b1;
            if (init_left_q == IW'(1)) phase_q <= PH_RUN;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign phase_o = phase_q;

  // ready may only appear on the heels of a finished init cycle
  assert_ready_after_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && $past(phase_q) != PH_RUN) |-> $past(cyc_done_i));
  assert_run_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phase_q) == PH_RUN |-> phase_q == PH_RUN);
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CYCLES = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYCLES + 1);
  logic [TW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == TW'(INTERVAL_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && wrap;

  generate
    if (INTERVAL_CYCLES > 1) begin : g_spacing
      assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/ref_pending.sv
module ref_pending #(
  parameter int MAX_PENDING = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o
);
  localparam int CW = $clog2(MAX_PENDING + 1);
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == CW'(MAX_PENDING));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   if (!full) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nonzero_o = (cnt_q != '0);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_PENDING));
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> nonzero_o);
endmodule

// File: rtl/ref_strobe_fsm.sv
module ref_strobe_fsm import dram_ref_pkg::*; #(
  parameter int ROW_W           = 11,
  parameter int CAS_LEAD_CYCLES = 1,
  parameter int RAS_LOW_CYCLES  = 5,
  parameter int RAS_PRE_CYCLES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int M1 = (CAS_LEAD_CYCLES > RAS_LOW_CYCLES) ? CAS_LEAD_CYCLES : RAS_LOW_CYCLES;
  localparam int MT = (M1 > RAS_PRE_CYCLES) ? M1 : RAS_PRE_CYCLES;
  localparam int TW = $clog2(MT + 1);

  strobe_st_e       st_q, st_d;
  logic [TW-1:0]    cnt_q, cnt_d;
  logic             mode_q;
  logic [ROW_W-1:0] row_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    done_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) st_d = (mode_i == MODE_ROR) ? ST_ROW_SETUP : ST_CAS_LEAD;
      end
      ST_CAS_LEAD: if (cnt_q == TW'(CAS_LEAD_CYCLES - 1)) begin
        st_d = ST_RAS_ACT; cnt_d = '0;
      end
      ST_ROW_SETUP: begin
        st_d = ST_RAS_ACT; cnt_d = '0;
      end
      ST_RAS_ACT: if (cnt_q == TW'(RAS_LOW_CYCLES - 1)) begin
        st_d = ST_PRECHG; cnt_d = '0;
      end
      ST_PRECHG: if (cnt_q == TW'(RAS_PRE_CYCLES - 1)) begin
        st_d = ST_IDLE; cnt_d = '0; done_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= MODE_CBR;
      row_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (st_q == ST_IDLE && start_i) mode_q <= mode_i;
      if (done_o && mode_q == MODE_ROR) row_q <= row_q + 1'b1;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign ras_n_o = (st_q != ST_RAS_ACT);
  assign cas_n_o = !(mode_q == MODE_CBR && (st_q == ST_CAS_LEAD || st_q == ST_RAS_ACT));
  assign we_n_o  = 1'b1;
  assign addr_o  = (mode_q == MODE_ROR && st_q != ST_IDLE) ? row_q : '0;

  assert_cbr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && mode_q == MODE_CBR) |-> $past(!cas_n_o));
  assert_cbr_we_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> we_n_o);
  assert_ror_cas_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && mode_q == MODE_ROR) |-> cas_n_o);
  assert_ror_addr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && mode_q == MODE_ROR) |-> $stable(addr_o));
  assert_row_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == MODE_ROR) |=> row_q == $past(row_q) + 1'b1);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import dram_ref_pkg::*; #(
  parameter int PWRUP_CYCLES    = 20000,
  parameter int INIT_REFRESHES  = 8,
  parameter int INTERVAL_CYCLES = 1562,
  parameter int MAX_PENDING     = 8,
  parameter int ROW_W           = 11,
  parameter int CAS_LEAD_CYCLES = 1,
  parameter int RAS_LOW_CYCLES  = 5,
  parameter int RAS_PRE_CYCLES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             bus_gnt_i,
  output logic             bus_req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             ready_o
);
  phase_e phase;
  logic   tick, pend_nz, busy, done, need, start;

  ref_phase_ctrl #(
    .PWRUP_CYCLES  (PWRUP_CYCLES),
    .INIT_REFRESHES(INIT_REFRESHES)
  ) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_done_i(done),
    .phase_o   (phase)
  );

  ref_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready_o),
    .tick_o(tick)
  );

  ref_pending #(.MAX_PENDING(MAX_PENDING)) i_pending (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .dec_i    (done && phase == PH_RUN),
    .nonzero_o(pend_nz)
  );

  ref_strobe_fsm #(
    .ROW_W          (ROW_W),
    .CAS_LEAD_CYCLES(CAS_LEAD_CYCLES),
    .RAS_LOW_CYCLES (RAS_LOW_CYCLES),
    .RAS_PRE_CYCLES (RAS_PRE_CYCLES)
  ) i_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .mode_i (mode_i),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .we_n_o (we_n_o),
    .addr_o (addr_o),
    .busy_o (busy),
    .done_o (done)
  );

  assign ready_o   = (phase == PH_RUN);
  assign need      = (phase == PH_INIT) || (ready_o && pend_nz);
  assign start     = need && bus_gnt_i && !busy;
  assign bus_req_o = need || busy;

  assert_strobe_granted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> bus_gnt_i);
  assert_silent_pwrup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_PWRUP |-> (!bus_req_o && ras_n_o && cas_n_o));
  assert_req_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> bus_req_o);
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int PWRUP = 200;
  localparam int NINIT = 8;
  localparam int IVAL  = 100;
  localparam int MAXP  = 4;
  localparam int RW    = 4;
  localparam int RASL  = 5;
  localparam int RASP  = 4;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, allow = 1'b1;
  logic bus_req, gnt, ras_n, cas_n, we_n, ready;
  logic [RW-1:0] addr;

  int n_checks = 0, n_fail = 0;
  int falls = 0, cbr_bad = 0, ror_bad = 0, width_bad = 0, pre_bad = 0, gnt_bad = 0;
  int low_cnt = 0, hi_cnt = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [RW-1:0] prev_addr = '0;
  logic [RW-1:0] addr_log [64];

  always #5 clk = ~clk;
  assign gnt = bus_req && allow;

  dram_refresh_seq #(
    .PWRUP_CYCLES(PWRUP), .INIT_REFRESHES(NINIT), .INTERVAL_CYCLES(IVAL),
    .MAX_PENDING(MAXP), .ROW_W(RW), .CAS_LEAD_CYCLES(1),
    .RAS_LOW_CYCLES(RASL), .RAS_PRE_CYCLES(RASP)
  ) i_dram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .bus_gnt_i(gnt),
    .bus_req_o(bus_req), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ready_o(ready)
  );

  // pin monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!ras_n || !cas_n) && !gnt) gnt_bad++;
      if (!we_n) cbr_bad++;
      if (!ras_n && prev_ras) begin
        if (falls < 64) addr_log[falls] = addr;
        falls++;
        if (hi_cnt < RASP && falls > 1) pre_bad++;
        if (mode == 1'b0 && prev_cas) cbr_bad++;
        if (mode == 1'b1 && addr != prev_addr) ror_bad++;
        low_cnt = 1;
      end else if (!ras_n) begin
        low_cnt++;
        if (mode == 1'b1 && addr != prev_addr) ror_bad++;
      end
      if (!ras_n && mode == 1'b0 && cas_n) cbr_bad++;
      if (!ras_n && mode == 1'b1 && !cas_n) ror_bad++;
      if (ras_n && !prev_ras) begin
        if (low_cnt != RASL) width_bad++;
        hi_cnt = 0;
      end
      if (ras_n) hi_cnt++;
    end
    prev_ras  = ras_n;
    prev_cas  = cas_n;
    prev_addr = addr;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    mode  = m;
    allow = 1'b1;
    repeat (3) @(negedge clk);
    falls  = 0;
    hi_cnt = 0;
    rst_n  = 1'b1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ready; i++) @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ras_n in reset", ras_n, 1);
    check("R1 cas_n in reset", cas_n, 1);
    check("R1 we_n in reset", we_n, 1);
    check("R1 bus_req in reset", bus_req, 0);
    check("R1 ready in reset", ready, 0);
  endtask

  task automatic test_pwrup_init();
    int cyc = 0;
    do_reset(1'b0);
    @(negedge clk);
    check("R1 ras_n after release", ras_n, 1);
    while (!bus_req && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    check_range("R2 pause length", cyc, PWRUP - 2, PWRUP + 2);
    check("R2 no strobe during pause", falls, 0);
    wait_ready();
    check("R3 ready after init", ready, 1);
    check("R3 init cycle count", falls, NINIT);
    repeat (20) @(negedge clk);
    check("R3 ready stays high", ready, 1);
  endtask

  task automatic test_interval();
    int f0;
    f0 = falls;
    repeat (10 * IVAL) @(negedge clk);
    check_range("R8 refreshes in 10 intervals", falls - f0, 9, 11);
    check("R4 CAS-before-RAS ordering violations", cbr_bad, 0);
    check("R7 RAS low width violations", width_bad, 0);
    check("R7 precharge violations", pre_bad, 0);
  endtask

  task automatic test_pending();
    int f0;
    while (bus_req) @(negedge clk);
    allow = 1'b0;
    f0 = falls;
    repeat ((MAXP + 3) * IVAL) @(negedge clk);
    check("R10 no strobe while grant withheld", falls - f0, 0);
    check("R10 request raised while owed", bus_req, 1);
    allow = 1'b1;
    repeat (60) @(negedge clk);
    check_range("R9 saturated burst size", falls - f0, MAXP, MAXP + 1);
    check("R10 strobe without grant", gnt_bad, 0);
    check("R7 precharge between burst cycles", pre_bad, 0);
  endtask

  task automatic test_ras_only();
    do_reset(1'b1);
    wait_ready();
    check("R3 RAS-only init count", falls, NINIT);
    while (falls < 20) @(negedge clk);
    repeat (20) @(negedge clk);
    check("R5 RAS-only cas/address violations", ror_bad, 0);
    for (int i = 0; i < 20; i++)
      check($sformatf("R6 row address of cycle %0d", i), int'(addr_log[i]), i % (1 << RW));
    check("R7 RAS-only width violations", width_bad, 0);
    check("R10 strobe without grant", gnt_bad, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    test_reset();
    test_pwrup_init();
    test_interval();
    test_pending();
    test_ras_only();
    report();
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule